// File: doc/BRIEF.md
# Watermark Sub-Region Access Filter

This block sits in front of one external memory region and decides, for every access, whether it may proceed. One programmable sub-region, bounded by a start and an end address, can carry its own security and privilege attributes. An access that falls inside the enabled sub-region is judged by those attributes. Every other access is judged by a base-region policy that arrives on input pins. The grant answer is combinational, so it can gate the access in the same cycle. A denied access also raises a one-cycle deny flag in the next cycle, together with the offending address.

Software programs the filter through a small write/read port. The port reaches a configuration word and the two address registers. A lock bit freezes all three registers until the next system reset. The reset contents depend on an 8-bit global security code that is sampled while reset is held. The code 0xB4 makes the whole memory start secure and privileged. Any other code, including 0xC3, leaves it open and lets the base policy apply.

Top module: `wm_subregion_filter`

## Requirements
- R1: During a synchronous reset (rst_n low at a rising edge) with sec_mode_i other than 0xB4, including 0xC3, the configuration reads 0x0, the start register reads 0 and the end register reads 0.
- R2: A reset with sec_mode_i equal to 0xB4 makes the configuration read 0x7 (enable, secure and privileged set, lock clear), the start read 0 and the end read all ones, so only secure privileged accesses are granted anywhere.
- R3: With the enable bit (cfg bit 0) clear, every valid access is granted exactly when the base rule passes. The base rule is that acc_sec_i equals base_sec_i, and acc_priv_i is 1 whenever base_priv_i is 1.
- R4: With enable set and start <= address <= end (both bounds inclusive), the secure bit (cfg bit 1) replaces base_sec_i. A value of 1 grants only secure accesses, and a value of 0 grants only non-secure accesses.
- R5: Inside the enabled sub-region, a privileged bit (cfg bit 2) of 1 grants only accesses with acc_priv_i = 1. A value of 0 grants both privileged and unprivileged accesses.
- R6: An address below start or above end uses the base rule. A start greater than end gives an empty sub-region, in which every address uses the base rule.
- R7: The lock bit (cfg bit 3) can be set by a configuration write. Once set, no write clears it, and only a reset returns it to 0.
- R8: While the lock bit is 1, writes to the configuration (select 0), start (select 1) and end (select 2) registers change none of their read values.
- R9: One cycle after a valid access that is denied, deny_o is 1 and deny_addr_o holds that access's address. After a granted or invalid access, deny_o is 0.
- R10: acc_grant_o is 0 whenever acc_valid_i is 0.
- R11: reg_rdata_o returns the current value of the selected register. Configuration bits 31:4 read 0, written values land bit for bit, and select 3 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low system reset |
| sec_mode_i | input | 8 | Global security code, sampled during reset |
| reg_wr_i | input | 1 | Register write strobe |
| reg_sel_i | input | 2 | Register select: 0 configuration, 1 start, 2 end |
| reg_wdata_i | input | DW | Write data |
| reg_rdata_o | output | DW | Read data of the selected register (combinational) |
| base_sec_i | input | 1 | Base-region security requirement |
| base_priv_i | input | 1 | Base-region privilege requirement |
| acc_valid_i | input | 1 | Access present this cycle |
| acc_addr_i | input | AW | Access address |
| acc_sec_i | input | 1 | Access is secure |
| acc_priv_i | input | 1 | Access is privileged |
| acc_grant_o | output | 1 | Access granted (combinational) |
| deny_o | output | 1 | Previous-cycle access was denied |
| deny_addr_o | output | AW | Address of the last denied access |

## Verification
The assertions check several properties on every cycle. The lock bit stays set once it is set. A locked register set stays unchanged across writes. The deny flag and its address follow every denied access one cycle later, and no flag follows a granted access. There is no grant without a valid access. Disabled and privileged sub-region decisions agree with the access rule. The reset contents for each security code, the inclusive window bounds, the empty window and the readback layout can only be shown by the bench's directed scenarios and its random mix of writes and accesses checked against a model.

// File: rtl/wmf_pkg.sv
package wmf_pkg;

  typedef enum logic [1:0] {
    SEL_CFG   = 2'd0,
    SEL_START = 2'd1,
    SEL_END   = 2'd2,
    SEL_NONE  = 2'd3
  } reg_sel_e;

  localparam int CFG_EN   = 0;
  localparam int CFG_SEC  = 1;
  localparam int CFG_PRIV = 2;
  localparam int CFG_LOCK = 3;
  localparam int CFG_BITS = 4;

  localparam logic [7:0] CODE_SECURE_BOOT = 8'hB4;

  typedef struct packed {
    logic lock;
    logic priv;
    logic sec;
    logic en;
  } cfg_t;

  // Attribute rule shared by base region and sub-region.
  function automatic logic attr_ok(logic need_sec, logic need_priv,
                                   logic is_sec, logic is_priv);
    return (need_sec == is_sec) && (!need_priv || is_priv);
  endfunction

endpackage

// File: rtl/wmf_regs.sv
module wmf_regs
  import wmf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sec_mode_i,
  input  logic          wr_i,
  input  logic [1:0]    sel_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o,
  output cfg_t          cfg_o,
  output logic [AW-1:0] start_o,
  output logic [AW-1:0] end_o
);

  cfg_t          cfg_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] end_q;
  logic          secure_boot;
  logic          wr_open;
  reg_sel_e      sel;

  assign secure_boot = (sec_mode_i == CODE_SECURE_BOOT);
  assign wr_open     = wr_i && !cfg_q.lock;
  assign sel         = reg_sel_e'(sel_i);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cfg_q.en   <= secure_boot;
      cfg_q.sec  <= secure_boot;
      cfg_q.priv <= secure_boot;
      cfg_q.lock <= 1'b0;
      start_q    <= '0;
      end_q      <= secure_boot ? '1 : '0;
    end else if (wr_open) begin
      case (sel)
        SEL_CFG: begin
          cfg_q.en   <= wdata_i[CFG_EN];
          cfg_q.sec  <= wdata_i[CFG_SEC];
          cfg_q.priv <= wdata_i[CFG_PRIV];
          cfg_q.lock <= wdata_i[CFG_LOCK];
        end
        SEL_START: start_q <= wdata_i[AW-1:0];
        SEL_END:   end_q   <= wdata_i[AW-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    rdata_o = '0;
    case (sel)
      SEL_CFG: begin
        rdata_o[CFG_EN]   = cfg_q.en;
        rdata_o[CFG_SEC]  = cfg_q.sec;
        rdata_o[CFG_PRIV] = cfg_q.priv;
        rdata_o[CFG_LOCK] = cfg_q.lock;
      end
      SEL_START: rdata_o[AW-1:0] = start_q;
      SEL_END:   rdata_o[AW-1:0] = end_q;
      default:   rdata_o = '0;
    endcase
  end

  assign cfg_o   = cfg_q;
  assign start_o = start_q;
  assign end_o   = end_q;

endmodule

// File: rtl/wmf_decide.sv
module wmf_decide
  import wmf_pkg::*;
#(
  parameter int AW = 32
) (
  input  cfg_t          cfg_i,
  input  logic [AW-1:0] start_i,
  input  logic [AW-1:0] end_i,
  input  logic          valid_i,
  input  logic [AW-1:0] addr_i,
  input  logic          sec_i,
  input  logic          priv_i,
  input  logic          base_sec_i,
  input  logic          base_priv_i,
  output logic          win_hit_o,
  output logic          grant_o
);

  // Inclusive window; start above end never matches.
  function automatic logic in_window(logic [AW-1:0] lo, logic [AW-1:0] hi,
                                     logic [AW-1:0] a);
    return (a >= lo) && (a <= hi);
  endfunction

  logic rule_ok;

  assign win_hit_o = cfg_i.en && in_window(start_i, end_i, addr_i);

  always_comb begin
    if (win_hit_o) rule_ok = attr_ok(cfg_i.sec, cfg_i.priv, sec_i, priv_i);
    else           rule_ok = attr_ok(base_sec_i, base_priv_i, sec_i, priv_i);
  end

  assign grant_o = valid_i && rule_ok;

endmodule

// File: rtl/wmf_deny.sv
module wmf_deny #(
  parameter int AW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          valid_i,
  input  logic          grant_i,
  input  logic [AW-1:0] addr_i,
  output logic          deny_o,
  output logic [AW-1:0] deny_addr_o
);

  logic denied;
  assign denied = valid_i && !grant_i;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      deny_o      <= 1'b0;
      deny_addr_o <= '0;
    end else begin
      deny_o <= denied;
      if (denied) deny_addr_o <= addr_i;
    end
  end

endmodule

// File: rtl/wm_subregion_filter.sv
module wm_subregion_filter
  import wmf_pkg::*;
#(
  parameter int AW = 32,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [7:0]    sec_mode_i,
  input  logic          reg_wr_i,
  input  logic [1:0]    reg_sel_i,
  input  logic [DW-1:0] reg_wdata_i,
  output logic [DW-1:0] reg_rdata_o,
  input  logic          base_sec_i,
  input  logic          base_priv_i,
  input  logic          acc_valid_i,
  input  logic [AW-1:0] acc_addr_i,
  input  logic          acc_sec_i,
  input  logic          acc_priv_i,
  output logic          acc_grant_o,
  output logic          deny_o,
  output logic [AW-1:0] deny_addr_o
);

  cfg_t          cfg_q;
  logic [AW-1:0] start_q;
  logic [AW-1:0] end_q;
  logic          win_hit;

  wmf_regs #(.AW(AW), .DW(DW)) u_regs (
    .clk        (clk),
    .rst_n      (rst_n),
    .sec_mode_i (sec_mode_i),
    .wr_i       (reg_wr_i),
    .sel_i      (reg_sel_i),
    .wdata_i    (reg_wdata_i),
    .rdata_o    (reg_rdata_o),
    .cfg_o      (cfg_q),
    .start_o    (start_q),
    .end_o      (end_q)
  );

  wmf_decide #(.AW(AW)) u_decide (
    .cfg_i       (cfg_q),
    .start_i     (start_q),
    .end_i       (end_q),
    .valid_i     (acc_valid_i),
    .addr_i      (acc_addr_i),
    .sec_i       (acc_sec_i),
    .priv_i      (acc_priv_i),
    .base_sec_i  (base_sec_i),
    .base_priv_i (base_priv_i),
    .win_hit_o   (win_hit),
    .grant_o     (acc_grant_o)
  );

  wmf_deny #(.AW(AW)) u_deny (
    .clk         (clk),
    .rst_n       (rst_n),
    .valid_i     (acc_valid_i),
    .grant_i     (acc_grant_o),
    .addr_i      (acc_addr_i),
    .deny_o      (deny_o),
    .deny_addr_o (deny_addr_o)
  );

endmodule

// File: rtl/wmf_chk.sv
module wmf_chk
  import wmf_pkg::*;
#(
  parameter int AW = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr_i,
  input logic          acc_valid_i,
  input logic [AW-1:0] acc_addr_i,
  input logic          acc_sec_i,
  input logic          acc_priv_i,
  input logic          base_sec_i,
  input logic          base_priv_i,
  input logic          acc_grant_o,
  input logic          deny_o,
  input logic [AW-1:0] deny_addr_o,
  input cfg_t          cfg_q,
  input logic [AW-1:0] start_q,
  input logic [AW-1:0] end_q,
  input logic          win_hit
);

  // R7
  lock_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_q.lock |=> cfg_q.lock);

  // R8
  locked_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.lock && reg_wr_i) |=> $stable({cfg_q, start_q, end_q}));

  // R9
  deny_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !acc_grant_o) |=>
      (deny_o && deny_addr_o == $past(acc_addr_i)));

  // R9
  no_false_deny_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(acc_valid_i && !acc_grant_o) |=> !deny_o);

  // R10
  grant_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !acc_valid_i |-> !acc_grant_o);

  // R3
  disabled_base_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && !cfg_q.en) |->
      (acc_grant_o == attr_ok(base_sec_i, base_priv_i, acc_sec_i, acc_priv_i)));

  // R5
  priv_sub_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_valid_i && win_hit && cfg_q.priv && !acc_priv_i) |-> !acc_grant_o);

endmodule

bind wm_subregion_filter wmf_chk #(.AW(AW)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_wr_i    (reg_wr_i),
  .acc_valid_i (acc_valid_i),
  .acc_addr_i  (acc_addr_i),
  .acc_sec_i   (acc_sec_i),
  .acc_priv_i  (acc_priv_i),
  .base_sec_i  (base_sec_i),
  .base_priv_i (base_priv_i),
  .acc_grant_o (acc_grant_o),
  .deny_o      (deny_o),
  .deny_addr_o (deny_addr_o),
  .cfg_q       (cfg_q),
  .start_q     (start_q),
  .end_q       (end_q),
  .win_hit     (win_hit)
);

// File: tb/tb_wm_subregion_filter.sv
module tb_wm_subregion_filter;

  localparam int CLK_PERIOD = 10;
  localparam int AW = 32;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [7:0]    sec_mode_i;
  logic          reg_wr_i;
  logic [1:0]    reg_sel_i;
  logic [DW-1:0] reg_wdata_i;
  logic [DW-1:0] reg_rdata_o;
  logic          base_sec_i, base_priv_i;
  logic          acc_valid_i;
  logic [AW-1:0] acc_addr_i;
  logic          acc_sec_i, acc_priv_i;
  logic          acc_grant_o;
  logic          deny_o;
  logic [AW-1:0] deny_addr_o;

  int checks = 0;
  int errors = 0;

  // Bench model of the register set
  logic          m_en, m_sec, m_priv, m_lock;
  logic [AW-1:0] m_start, m_end;

  always #(CLK_PERIOD/2) clk = ~clk;

  wm_subregion_filter #(.AW(AW), .DW(DW)) dut (.*);

  function automatic logic rule(logic rs, logic rp, logic s, logic p);
    if (rs != s) return 1'b0;
    if (rp && !p) return 1'b0;
    return 1'b1;
  endfunction

  function automatic logic exp_grant(logic v, logic [AW-1:0] a, logic s, logic p,
                                     logic bs, logic bp);
    if (!v) return 1'b0;
    if (m_en && !(a < m_start) && !(a > m_end)) return rule(m_sec, m_priv, s, p);
    return rule(bs, bp, s, p);
  endfunction

  function automatic logic [DW-1:0] exp_read(logic [1:0] sel);
    case (sel)
      2'd0: return {28'd0, m_lock, m_priv, m_sec, m_en};
      2'd1: return m_start;
      2'd2: return m_end;
      default: return '0;
    endcase
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic do_reset(logic [7:0] code);
    @(negedge clk);
    rst_n = 1'b0; sec_mode_i = code;
    reg_wr_i = 1'b0; acc_valid_i = 1'b0;
    repeat (2) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    m_lock = 1'b0; m_start = '0;
    m_en = (code == 8'hB4); m_sec = m_en; m_priv = m_en;
    m_end = m_en ? '1 : '0;
  endtask

  task automatic wr(logic [1:0] sel, logic [DW-1:0] data);
    @(negedge clk);
    reg_wr_i = 1'b1; reg_sel_i = sel; reg_wdata_i = data;
    @(posedge clk);
    #1 reg_wr_i = 1'b0;
    if (!m_lock) begin
      case (sel)
        2'd0: {m_lock, m_priv, m_sec, m_en} = data[3:0];
        2'd1: m_start = data;
        2'd2: m_end = data;
        default: ;
      endcase
    end
  endtask

  task automatic rd(string req, logic [1:0] sel);
    @(negedge clk);
    reg_sel_i = sel;
    #1 check(req, reg_rdata_o, exp_read(sel));
  endtask

  task automatic acc(string req, logic v, logic [AW-1:0] a, logic s, logic p,
                     logic bs, logic bp);
    logic eg;
    @(negedge clk);
    acc_valid_i = v; acc_addr_i = a; acc_sec_i = s; acc_priv_i = p;
    base_sec_i = bs; base_priv_i = bp;
    eg = exp_grant(v, a, s, p, bs, bp);
    #1 check(req, acc_grant_o, eg);
    @(posedge clk);
    #1;
    check("R9 deny flag", deny_o, v && !eg);
    if (v && !eg) check("R9 deny addr", deny_addr_o, a);
    acc_valid_i = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; sec_mode_i = 8'hC3; reg_wr_i = 1'b0; reg_sel_i = '0;
    reg_wdata_i = '0; base_sec_i = 1'b0; base_priv_i = 1'b0;
    acc_valid_i = 1'b0; acc_addr_i = '0; acc_sec_i = 1'b0; acc_priv_i = 1'b0;
    void'($urandom(32'd2024));

    // R1 reset with 0xC3 and with an unrelated code
    do_reset(8'hC3);
    rd("R1 cfg", 2'd0); rd("R1 start", 2'd1); rd("R1 end", 2'd2);
    acc("R3 base after reset", 1'b1, 32'h0, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R3 base secure rule", 1'b1, 32'h0, 1'b0, 1'b0, 1'b1, 1'b0);
    do_reset(8'h00);
    rd("R1 cfg other code", 2'd0); rd("R1 end other code", 2'd2);

    // R2 secure boot
    do_reset(8'hB4);
    rd("R2 cfg", 2'd0); rd("R2 start", 2'd1); rd("R2 end", 2'd2);
    acc("R2 nonsecure denied", 1'b1, 32'h1234, 1'b0, 1'b1, 1'b0, 1'b0);
    acc("R2 secure unpriv denied", 1'b1, 32'hFFFF_FFFF, 1'b1, 1'b0, 1'b1, 1'b0);
    acc("R2 secure priv granted", 1'b1, 32'h0, 1'b1, 1'b1, 1'b0, 1'b0);

    // R4 / R6 window with secure attribute
    do_reset(8'hC3);
    wr(2'd1, 32'h100); wr(2'd2, 32'h1FF); wr(2'd0, 32'h3);
    acc("R4 secure inside granted", 1'b1, 32'h150, 1'b1, 1'b0, 1'b0, 1'b0);
    acc("R4 nonsecure inside denied", 1'b1, 32'h150, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R4 low bound inside", 1'b1, 32'h100, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R4 high bound inside", 1'b1, 32'h1FF, 1'b1, 1'b0, 1'b0, 1'b0);
    acc("R6 below start base", 1'b1, 32'hFF, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R6 above end base", 1'b1, 32'h200, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R10 no valid no grant", 1'b0, 32'h150, 1'b1, 1'b0, 1'b0, 1'b0);

    // R5 privileged attribute, non-secure window
    wr(2'd0, 32'h5);
    acc("R5 unpriv denied", 1'b1, 32'h180, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R5 priv granted", 1'b1, 32'h180, 1'b0, 1'b1, 1'b0, 1'b0);
    wr(2'd0, 32'h1);
    acc("R5 priv clear unpriv granted", 1'b1, 32'h180, 1'b0, 1'b0, 1'b1, 1'b1);

    // R3 disabled window falls back to base
    wr(2'd0, 32'h6);
    acc("R3 disabled uses base deny", 1'b1, 32'h180, 1'b1, 1'b1, 1'b0, 1'b0);
    acc("R3 disabled uses base priv", 1'b1, 32'h180, 1'b0, 1'b0, 1'b0, 1'b1);

    // R6 empty window
    wr(2'd0, 32'h3); wr(2'd1, 32'h300); wr(2'd2, 32'h200);
    acc("R6 empty window base", 1'b1, 32'h250, 1'b0, 1'b0, 1'b0, 1'b0);
    acc("R6 empty window start addr", 1'b1, 32'h300, 1'b0, 1'b0, 1'b0, 1'b0);

    // R11 readback layout
    wr(2'd0, 32'hFFFF_FFF7);
    rd("R11 cfg upper bits zero", 2'd0);
    wr(2'd1, 32'hDEAD_BEEF);
    rd("R11 start readback", 2'd1);
    rd("R11 select 3 zero", 2'd3);

    // R7 / R8 lock
    wr(2'd0, 32'h9);
    rd("R7 lock set", 2'd0);
    wr(2'd0, 32'h0);
    rd("R7 lock not cleared", 2'd0);
    wr(2'd1, 32'h55); wr(2'd2, 32'h66);
    rd("R8 start frozen", 2'd1); rd("R8 end frozen", 2'd2);
    do_reset(8'hC3);
    rd("R7 reset clears lock", 2'd0);

    // Random mix
    do_reset(8'hC3);
    for (int i = 0; i < 400; i++) begin
      int op = $urandom_range(0, 9);
      if (op < 3) begin
        logic [1:0] sel = 2'($urandom_range(0, 2));
        logic [DW-1:0] d;
        if (sel == 2'd0) begin
          d = 32'($urandom_range(0, 15));
          if ($urandom_range(0, 29) != 0) d[3] = 1'b0;
        end else d = 32'($urandom_range(0, 255));
        wr(sel, d);
        rd("R11 random readback", sel);
      end else begin
        acc("R4 random access", 1'($urandom_range(0, 5) != 0),
            32'($urandom_range(0, 255)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)),
            1'($urandom_range(0, 1)));
      end
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule